// File: doc/BRIEF.md
# Handshaked FIFO Drain Controller

This block sits on the read side of a strobe-handshake FIFO and drains it toward a consumer. It drives the FIFO's shift-out strobe, registers the word that is present when the strobe rises, and gives the consumer a one-cycle valid pulse for each word it captures. Every strobe is handshaked against the FIFO's ready flag. The strobe rises only while the flag is high and falls only after the flag has dropped, so no strobe is ever too short for the FIFO to register.

When the FIFO has just left the empty state, its first shift-out can be lost during a short start-up window. The controller offers two start policies to deal with this. In guarded mode the first strobe after empty is held off for a fixed number of clock cycles, and later reads go at full rate. In half-full mode draining does not begin until the occupancy count supplied with the data is above half the FIFO depth, which keeps clear of the window. Several FIFOs laid side by side for a wider word are drained together: their ready flags are ANDed into one composite flag and their data buses are captured as a single word. All inputs are taken as synchronous to `clk`.

Top module: `fifo_drain_ctrl`

## Requirements
- R1: While `shift_out` is high it stays high for as long as the composite ready is sampled high. It falls on the first clock edge at which the composite ready is sampled low.
- R2: On the clock edge where `shift_out` rises, `word_q` loads `lane_data` and `word_vld` goes high in that same cycle.
- R3: In guarded mode (`start_mode` = 0), the first `shift_out` rise after the empty state happens exactly GUARD_CYC+1 clock edges after the first edge that samples the composite ready high. GUARD_CYC = ceil(GUARD_NS / CLK_PERIOD_NS), which is 10 with the default values.
- R4: After the first read, a later read needs no guard. `shift_out` rises on the edge after the composite ready is sampled high again.
- R5: The controller returns to the empty state when the composite ready stays low for EMPTY_CYC consecutive edges (default 4) while the strobe is low. The next read after that is guarded again as in R3.
- R6: In half-full mode (`start_mode` = 1), no strobe is issued from the empty state until `fifo_level` is greater than DEPTH/2 (32 by default). Once started, draining continues with no guard delay until the empty state is re-entered.
- R7: A new `shift_out` rise happens only on an edge where `cons_ready` is sampled high. While `cons_ready` is low, no word is taken.
- R8: The composite ready is the AND of all `lane_rdy` bits. With any lane low, no strobe is issued.
- R9: `word_vld` is high for exactly one cycle per captured word. Words reach the consumer in the order they were written into the FIFO.
- R10: While `rst` is high, `shift_out`, `word_vld` and `word_q` are all 0, and the controller is in the empty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_mode | input | 1 | 0 = start at once with guard delay, 1 = start above half full |
| cons_ready | input | 1 | Consumer accepts a new word |
| lane_rdy | input | LANES | Output-ready flag of each parallel FIFO |
| lane_data | input | LANES*LANE_W | Concatenated data buses of the parallel FIFOs |
| fifo_level | input | $clog2(DEPTH+1) | Occupancy estimate (writes minus reads) |
| shift_out | output | 1 | Registered shift-out strobe to every FIFO |
| word_q | output | LANES*LANE_W | Captured data word |
| word_vld | output | 1 | One-cycle pulse per captured word |

## Verification
A corrupted strobe state shows up at once on `shift_out`. A strobe that drops while the ready flag is still high, or that never drops, changes the number of words the FIFO model pops, and the very next captured word then differs from the scoreboard's entry. A guard counter that loads the wrong value, or that fires after a consecutive read, shows up in the first rise-to-strobe gap as a count other than GUARD_CYC+2 or 1 at the sampling point. An empty-detection counter that is wrong shows up in the gap of the next isolated word. A broken start gate or accept gate shows up as a strobe during a window where the bench expects none.

// File: rtl/drain_pkg.sv
package drain_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY     = 2'd0,
    ST_GUARD     = 2'd1,
    ST_STROBE_HI = 2'd2,
    ST_STROBE_LO = 2'd3
  } drain_st_e;

  localparam logic MODE_GUARDED = 1'b0;
  localparam logic MODE_HALF    = 1'b1;

endpackage

// File: rtl/drain_rdy_merge.sv
module drain_rdy_merge #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] lane_rdy,
  output logic             rdy_all
);

  logic [LANES:0] chain;

  assign chain[0] = 1'b1;

  for (genvar i = 0; i < LANES; i++) begin : g_and
    assign chain[i+1] = chain[i] & lane_rdy[i];
  end

  assign rdy_all = chain[LANES];

endmodule

// File: rtl/drain_start_gate.sv
module drain_start_gate
  import drain_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             start_mode,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             go_ok,
  output logic             use_guard
);

  localparam int HALF_MARK = DEPTH / 2;
  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(HALF_MARK);

  always_comb begin
    if (start_mode == MODE_HALF) begin
      go_ok     = (fifo_level > HALF_LVL);
      use_guard = 1'b0;
    end else begin
      go_ok     = 1'b1;
      use_guard = 1'b1;
    end
  end

endmodule

// File: rtl/drain_strobe_fsm.sv
module drain_strobe_fsm
  import drain_pkg::*;
#(
  parameter int GUARD_CYC = 10,
  parameter int EMPTY_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_all,
  input  logic go_ok,
  input  logic use_guard,
  input  logic cons_ready,
  output logic shift_out,
  output logic cap_en
);

  localparam int CNT_MAX = (GUARD_CYC > EMPTY_CYC) ? GUARD_CYC : EMPTY_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] GUARD_LOAD = CNT_W'(GUARD_CYC - 1);
  localparam logic [CNT_W-1:0] EMPTY_LAST = CNT_W'(EMPTY_CYC - 1);

  drain_st_e        st;
  logic [CNT_W-1:0] cnt;

  assign cap_en = (st == ST_STROBE_LO) && rdy_all && cons_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_EMPTY;
      cnt       <= '0;
      shift_out <= 1'b0;
    end else begin
      case (st)
        ST_EMPTY: begin
          if (rdy_all && go_ok) begin
            if (use_guard) begin
              st  <= ST_GUARD;
              cnt <= GUARD_LOAD;
            end else begin
              st  <= ST_STROBE_LO;
              cnt <= '0;
            end
          end
        end
        ST_GUARD: begin
          if (cnt == '0) begin
            st <= ST_STROBE_LO;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE_LO: begin
          if (cap_en) begin
            st        <= ST_STROBE_HI;
            shift_out <= 1'b1;
            cnt       <= '0;
          end else if (rdy_all) begin
            cnt <= '0;
          end else if (cnt == EMPTY_LAST) begin
            st  <= ST_EMPTY;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STROBE_HI: begin
          if (!rdy_all) begin
            st        <= ST_STROBE_LO;
            shift_out <= 1'b0;
            cnt       <= '0;
          end
        end
        default: st <= ST_EMPTY;
      endcase
    end
  end

  logic [CNT_W:0] guard_run;
  always_ff @(posedge clk) begin
    if (rst) guard_run <= '0;
    else if (st == ST_GUARD) guard_run <= guard_run + 1'b1;
    else guard_run <= '0;
  end

  AST_SO_HELD_WHILE_RDY: assert property (@(posedge clk) disable iff (rst)
    (shift_out && rdy_all) |=> shift_out); // R1
  AST_SO_FALL_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_out) |-> !$past(rdy_all)); // R1
  AST_GUARD_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STROBE_LO && $past(st) == ST_GUARD) |-> (guard_run == (CNT_W+1)'(GUARD_CYC))); // R3

endmodule

// File: rtl/drain_word_capture.sv
module drain_word_capture #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word_q,
  output logic              word_vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= cap_en;
      if (cap_en) word_q <= din;
    end
  end

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld); // R9

endmodule

// File: rtl/fifo_drain_ctrl.sv
module fifo_drain_ctrl
  import drain_pkg::*;
#(
  parameter int LANES         = 2,
  parameter int LANE_W        = 4,
  parameter int DEPTH         = 64,
  parameter int CLK_PERIOD_NS = 4,
  parameter int GUARD_NS      = 40,
  parameter int EMPTY_CYC     = 4,
  localparam int WORD_W       = LANES * LANE_W,
  localparam int LVL_W        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_mode,
  input  logic              cons_ready,
  input  logic [LANES-1:0]  lane_rdy,
  input  logic [WORD_W-1:0] lane_data,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              shift_out,
  output logic [WORD_W-1:0] word_q,
  output logic              word_vld
);

  localparam int GUARD_CYC = (GUARD_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic rdy_all;
  logic go_ok;
  logic use_guard;
  logic cap_en;

  drain_rdy_merge #(.LANES(LANES)) u_merge (
    .lane_rdy (lane_rdy),
    .rdy_all  (rdy_all)
  );

  drain_start_gate #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_gate (
    .start_mode (start_mode),
    .fifo_level (fifo_level),
    .go_ok      (go_ok),
    .use_guard  (use_guard)
  );

  drain_strobe_fsm #(.GUARD_CYC(GUARD_CYC), .EMPTY_CYC(EMPTY_CYC)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .rdy_all    (rdy_all),
    .go_ok      (go_ok),
    .use_guard  (use_guard),
    .cons_ready (cons_ready),
    .shift_out  (shift_out),
    .cap_en     (cap_en)
  );

  drain_word_capture #(.WORD_W(WORD_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .din      (lane_data),
    .word_q   (word_q),
    .word_vld (word_vld)
  );

  AST_VLD_AT_SO_RISE: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $rose(shift_out)); // R2
  AST_RISE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_out) |-> ($past(cons_ready) && $past(&lane_rdy))); // R7 R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!shift_out && !word_vld)); // R10

endmodule

// File: tb/fifo_drain_ctrl_test.sv
module fifo_drain_ctrl_test;

  localparam int LANES = 2, LANE_W = 4, DEPTH = 64;
  localparam int CLK_NS = 4, GUARD_NS = 40;
  localparam int WORD_W = LANES * LANE_W;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int G = (GUARD_NS + CLK_NS - 1) / CLK_NS;
  localparam int OR_LAT = 2;

  logic clk = 1'b0;
  logic rst, start_mode, cons_ready;
  logic [LANES-1:0] lane_rdy;
  logic [WORD_W-1:0] lane_data;
  logic [LVL_W-1:0] fifo_level;
  logic shift_out, word_vld;
  logic [WORD_W-1:0] word_q;

  always #2 clk = ~clk;

  fifo_drain_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH),
                    .CLK_PERIOD_NS(CLK_NS), .GUARD_NS(GUARD_NS), .EMPTY_CYC(4)) uut (
    .clk(clk), .rst(rst), .start_mode(start_mode), .cons_ready(cons_ready),
    .lane_rdy(lane_rdy), .lane_data(lane_data), .fifo_level(fifo_level),
    .shift_out(shift_out), .word_q(word_q), .word_vld(word_vld));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [WORD_W-1:0] model_q[$];
  logic [WORD_W-1:0] exp_q[$];
  int gap_q[$];
  int gap = 0, so_rises = 0, vld_total = 0, pushed = 0, low_cnt = 0;
  logic fifo_or = 1'b0, block = 1'b0, hold = 1'b0, so_prev = 1'b0, vld_prev = 1'b0;

  assign lane_rdy = {fifo_or & ~block, fifo_or};

  function automatic void chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // FIFO model: strobe handshake with OR_LAT low cycles before ready
  initial begin
    lane_data = '0;
    fifo_level = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        fifo_or = 1'b0; low_cnt = 0;
      end else if (fifo_or && shift_out && !hold) begin
        fifo_or = 1'b0;
        void'(model_q.pop_front());
        low_cnt = 0;
      end else if (!fifo_or && !shift_out && model_q.size() > 0) begin
        low_cnt++;
        if (low_cnt >= OR_LAT) begin
          fifo_or = 1'b1;
          lane_data = model_q[0];
          low_cnt = 0;
        end
      end
      fifo_level = LVL_W'(model_q.size());
    end
  end

  // scoreboard monitor and strobe-gap monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst) begin
        if (word_vld) begin
          vld_total++;
          if (exp_q.size() == 0) chk(0, "R9 unexpected word", int'(word_q), -1);
          else begin
            logic [WORD_W-1:0] e;
            e = exp_q.pop_front();
            chk(word_q == e, "R2 captured word", int'(word_q), int'(e));
          end
          if (vld_prev) chk(0, "R9 valid longer than one cycle", 2, 1);
        end
        if (shift_out && !so_prev) begin
          gap_q.push_back(gap); so_rises++; gap = 0;
        end else if (fifo_or && !shift_out) gap++;
      end
      so_prev = shift_out;
      vld_prev = word_vld;
    end
  end

  task automatic push(input logic [WORD_W-1:0] w);
    @(negedge clk); #2;
    model_q.push_back(w);
    exp_q.push_back(w);
    pushed++;
  endtask

  task automatic wait_drain(input string tag);
    int t = 0;
    while (exp_q.size() != 0 && t < 3000) begin @(negedge clk); t++; end
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    repeat (12) @(negedge clk);
  endtask

  task automatic clear_gaps();
    @(negedge clk); #2;
    gap_q.delete(); gap = 0;
  endtask

  initial begin
    int r0;
    rst = 1'b1; start_mode = 1'b0; cons_ready = 1'b1;
    repeat (5) @(negedge clk); #1;
    chk(shift_out == 1'b0, "R10 reset shift_out", shift_out, 0);
    chk(word_vld == 1'b0, "R10 reset word_vld", word_vld, 0);
    chk(word_q == '0, "R10 reset word_q", int'(word_q), 0);
    rst = 1'b0;

    // guarded first read, then consecutive reads
    clear_gaps();
    push(8'h3C); push(8'hA5); push(8'h0F);
    wait_drain("R4 drain three");
    chk(gap_q.size() == 3, "R3 strobe count", gap_q.size(), 3);
    if (gap_q.size() == 3) begin
      chk(gap_q[0] == G + 2, "R3 guard gap", gap_q[0], G + 2);
      chk(gap_q[1] == 1, "R4 second gap", gap_q[1], 1);
      chk(gap_q[2] == 1, "R4 third gap", gap_q[2], 1);
    end

    // re-entry of empty brings the guard back
    repeat (20) @(negedge clk);
    clear_gaps();
    push(8'h96);
    wait_drain("R5 drain one");
    chk(gap_q.size() == 1 && gap_q[0] == G + 2, "R5 guard after empty",
        (gap_q.size() > 0) ? gap_q[0] : -1, G + 2);

    // strobe held while ready stays high
    hold = 1'b1;
    r0 = vld_total;
    push(8'h71);
    begin
      int t = 0;
      while (!shift_out && t < 200) begin @(negedge clk); t++; end
    end
    repeat (10) @(negedge clk); #1;
    chk(shift_out == 1'b1, "R1 strobe held", shift_out, 1);
    chk(vld_total == r0 + 1, "R9 one word per strobe", vld_total - r0, 1);
    hold = 1'b0;
    @(negedge clk); #1;
    chk(shift_out == 1'b1, "R1 strobe before ready falls", shift_out, 1);
    @(negedge clk); #1;
    chk(shift_out == 1'b0, "R1 strobe after ready falls", shift_out, 0);
    wait_drain("R1 drain held");

    // consumer stall
    cons_ready = 1'b0;
    r0 = so_rises;
    push(8'h12); push(8'h34);
    repeat (40) @(negedge clk); #1;
    chk(so_rises == r0, "R7 no strobe while stalled", so_rises - r0, 0);
    cons_ready = 1'b1;
    wait_drain("R7 drain after stall");
    chk(so_rises == r0 + 2, "R7 strobes after release", so_rises - r0, 2);

    // one lane not ready
    block = 1'b1;
    r0 = so_rises;
    push(8'hE4);
    repeat (40) @(negedge clk); #1;
    chk(so_rises == r0, "R8 no strobe with lane low", so_rises - r0, 0);
    block = 1'b0;
    wait_drain("R8 drain after lane");

    // half-full start policy
    start_mode = 1'b1;
    r0 = so_rises;
    for (int i = 0; i < DEPTH / 2; i++) push(WORD_W'(i * 7 + 1));
    repeat (40) @(negedge clk); #1;
    chk(so_rises == r0, "R6 hold at half", so_rises - r0, 0);
    push(8'hC3);
    wait_drain("R6 drain above half");
    chk(so_rises == r0 + DEPTH / 2 + 1, "R6 all drained", so_rises - r0, DEPTH / 2 + 1);
    start_mode = 1'b0;

    chk(vld_total == pushed, "R9 total words", vld_total, pushed);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", vld_total, pushed);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule